// File: doc/BRIEF.md
# Dual-Enable Static Memory Array

This block is a synthesizable model of an 8192-word by 8-bit static memory. It has a 13-bit address and four control inputs: a low-true select, a high-true select, a low-true output drive enable and a low-true store enable. Together these inputs put the array in one of five modes. The modes are sleep, unselected, quiet, read and store. The bidirectional data pin is split into three signals: a write data input, a read data output and an output-enable flag. A pad ring or a wrapper can use these three to build a real tri-state pin.

Stores are taken on the rising clock edge in any cycle where the store condition holds. Read data comes straight from the array in the same cycle by default. With `READ_LATENCY = 1` it comes one cycle later through a register stage. Inside the block, the array is kept as four byte-wide lane banks of 2048 entries each. The low address bits pick the lane. A `sleep` flag tells the surrounding logic when the low-true select is released.

Top module: `sram_dual_en`

## Requirements
- R1: Each of the 8192 addresses holds its own 8-bit value. Storing to one address never changes another. The low two address bits select the lane bank and the upper eleven select the line.
- R2: A store to `addr` of `wdata` takes place at the rising clock edge only when `sel_lo_n`=0, `sel_hi`=1 and `store_n`=0. The value of `drive_n` has no effect on a store.
- R3: When `sel_lo_n`=0, `sel_hi`=1, `drive_n`=0 and `store_n`=1, `rdata_oe`=1 and `rdata` equals the value stored at `addr`. With `READ_LATENCY`=0 both appear in the same cycle, including the cycle right after a store to that address.
- R4: When `store_n`=0, `rdata_oe`=0, whatever the two selects and `drive_n` are.
- R5: When `sel_lo_n`=1, `sleep`=1, `rdata_oe`=0 and no store takes place, for any value of the other inputs.
- R6: When `sel_hi`=0 and `sel_lo_n`=0, `sleep`=0, `rdata_oe`=0 and no store takes place.
- R7: When both selects are active and `drive_n`=1 with `store_n`=1, `rdata_oe`=0 and no store takes place.
- R8: Whenever `rdata_oe`=0, `rdata` is all zeros.
- R9: With `READ_LATENCY`=1, `rdata` and `rdata_oe` show the read result of the previous clock cycle. In the cycle after a non-read cycle, `rdata_oe`=0.
- R10: While `rst_n`=0 and after its release, until the first read, `rdata_oe`=0 for both latency settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores and the optional read register act on its rising edge |
| rst_n | input | 1 | Active-low reset of the read register stage |
| sel_lo_n | input | 1 | Low-true select; when high it forces sleep |
| sel_hi | input | 1 | High-true select |
| drive_n | input | 1 | Low-true output drive enable |
| store_n | input | 1 | Low-true store enable |
| addr | input | 13 | Word address |
| wdata | input | 8 | Data to store |
| rdata | output | 8 | Read data, zero when not driven |
| rdata_oe | output | 1 | High when the data pin should be driven |
| sleep | output | 1 | High when the low-true select is released |

## Verification
Two events can meet in the same cycle of the port: the commit of a store at one clock edge, and a combinational read of that same address in the very next cycle. The bench provokes this for every address. It stores a fresh pattern and, right after the edge, switches to a read of that address. The read must return the new byte and not the old one. A second case meets in the same cycle too: a store request arrives while one of the selects is inactive. The bench judges it by reading the address back later, where it must find the earlier value unchanged.

// File: rtl/sram_dual_en_pkg.sv
package sram_dual_en_pkg;

    typedef enum logic [2:0] {
        MODE_SLEEP = 3'd0,
        MODE_UNSEL = 3'd1,
        MODE_QUIET = 3'd2,
        MODE_READ  = 3'd3,
        MODE_STORE = 3'd4
    } mode_e;

    typedef struct packed {
        logic sel_lo_n;
        logic sel_hi;
        logic drive_n;
        logic store_n;
    } ctrl_t;

    // Priority: low-true select first, then high-true select, then store over drive.
    function automatic mode_e decode_mode(input ctrl_t c);
        if (c.sel_lo_n)      return MODE_SLEEP;
        else if (!c.sel_hi)  return MODE_UNSEL;
        else if (!c.store_n) return MODE_STORE;
        else if (!c.drive_n) return MODE_READ;
        else                 return MODE_QUIET;
    endfunction

endpackage

// File: rtl/sram_dual_en_mode_dec.sv
module sram_dual_en_mode_dec
    import sram_dual_en_pkg::*;
(
    input  ctrl_t ctrl,
    output logic  sleep,
    output logic  rd_fire,
    output logic  wr_fire
);

    mode_e mode;

    always_comb begin
        mode    = decode_mode(ctrl);
        sleep   = (mode == MODE_SLEEP);
        rd_fire = (mode == MODE_READ);
        wr_fire = (mode == MODE_STORE);
    end

endmodule

// File: rtl/sram_dual_en_bank.sv
module sram_dual_en_bank #(
    parameter int DATA_W    = 8,
    parameter int LINE_W    = 11,
    parameter int LANE_BITS = 2
) (
    input  logic                          clk,
    input  logic                          wr_fire,
    input  logic [LINE_W+LANE_BITS-1:0]   addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             raw_data
);

    localparam int LANES = 1 << LANE_BITS;
    localparam int DEPTH = 1 << LINE_W;

    logic [LINE_W-1:0]    line_idx;
    logic [LANE_BITS-1:0] lane_idx;
    logic [DATA_W-1:0]    lane_rd [LANES];

    assign line_idx = addr[LINE_W+LANE_BITS-1:LANE_BITS];
    assign lane_idx = addr[LANE_BITS-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_fire && (lane_idx == LANE_BITS'(g))) begin
                mem[line_idx] <= wdata;
            end
        end

        assign lane_rd[g] = mem[line_idx];
    end

    assign raw_data = lane_rd[lane_idx];

endmodule

// File: rtl/sram_dual_en_rdstage.sv
module sram_dual_en_rdstage #(
    parameter int DATA_W       = 8,
    parameter int READ_LATENCY = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire,
    input  logic [DATA_W-1:0] raw_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_now;
    rd_t rd_d;
    rd_t rd_q;

    always_comb begin
        rd_now.oe   = rd_fire;
        rd_now.data = rd_fire ? raw_data : '0;
        rd_d        = rd_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    if (READ_LATENCY == 0) begin : g_comb
        assign rdata    = rd_now.data;
        assign rdata_oe = rd_now.oe;
    end else begin : g_reg
        assign rdata    = rd_q.data;
        assign rdata_oe = rd_q.oe;
    end

endmodule

// File: rtl/sram_dual_en.sv
module sram_dual_en
    import sram_dual_en_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int LANE_BITS    = 2,
    parameter int READ_LATENCY = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              drive_n,
    input  logic              store_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              sleep
);

    localparam int LINE_W = ADDR_W - LANE_BITS;

    ctrl_t             ctrl;
    logic              rd_fire;
    logic              wr_fire;
    logic [DATA_W-1:0] raw_data;

    assign ctrl = '{sel_lo_n: sel_lo_n, sel_hi: sel_hi, drive_n: drive_n, store_n: store_n};

    sram_dual_en_mode_dec u_dec (
        .ctrl    (ctrl),
        .sleep   (sleep),
        .rd_fire (rd_fire),
        .wr_fire (wr_fire)
    );

    sram_dual_en_bank #(
        .DATA_W    (DATA_W),
        .LINE_W    (LINE_W),
        .LANE_BITS (LANE_BITS)
    ) u_bank (
        .clk      (clk),
        .wr_fire  (wr_fire),
        .addr     (addr),
        .wdata    (wdata),
        .raw_data (raw_data)
    );

    sram_dual_en_rdstage #(
        .DATA_W       (DATA_W),
        .READ_LATENCY (READ_LATENCY)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fire  (rd_fire),
        .raw_data (raw_data),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

endmodule

// File: rtl/sram_dual_en_chk.sv
module sram_dual_en_chk #(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int READ_LATENCY = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_lo_n,
    input logic              sel_hi,
    input logic              drive_n,
    input logic              store_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input logic              sleep
);

    logic rd_cond;
    logic wr_cond;
    assign rd_cond = !sel_lo_n && sel_hi && !drive_n && store_n;
    assign wr_cond = !sel_lo_n && sel_hi && !store_n;

    // R4: a store request never drives the pin (same-cycle path)
    a_r4_store_no_drive: assert property (@(posedge clk) disable iff (!rst_n || READ_LATENCY != 0)
        !store_n |-> !rdata_oe);

    // R5: a held sleep keeps the pin silent for either latency
    a_r5_sleep_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lo_n && $past(sel_lo_n)) |-> (sleep && !rdata_oe));

    // R6: a held inactive high-true select keeps the pin silent
    a_r6_unsel_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_hi && $past(!sel_hi)) |-> !rdata_oe);

    // R7: selected but neither driving nor storing stays silent
    a_r7_quiet_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_n && store_n && $past(drive_n && store_n)) |-> !rdata_oe);

    // R8: undriven data is zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));

    // R3: a read right after a store to the same address returns the stored byte
    a_r3_read_after_store: assert property (@(posedge clk) disable iff (!rst_n || READ_LATENCY != 0)
        (rd_cond && $past(wr_cond) && (addr == $past(addr))) |-> (rdata == $past(wdata)));

    // R9: registered output only follows a read in the previous cycle
    a_r9_pipe_source: assert property (@(posedge clk) disable iff (!rst_n || READ_LATENCY != 1)
        rdata_oe |-> $past(rd_cond));

endmodule

bind sram_dual_en sram_dual_en_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .READ_LATENCY (READ_LATENCY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_lo_n (sel_lo_n),
    .sel_hi   (sel_hi),
    .drive_n  (drive_n),
    .store_n  (store_n),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .sleep    (sleep)
);

// File: tb/sram_dual_en_tb.sv
module sram_dual_en_tb;

    localparam int AW    = 13;
    localparam int DW    = 8;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_lo_n = 1'b1;
    logic          sel_hi = 1'b0;
    logic          drive_n = 1'b1;
    logic          store_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata, rdata_p;
    logic          rdata_oe, rdata_oe_p;
    logic          sleep, sleep_p;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] model [WORDS];

    always #2 clk = ~clk;

    sram_dual_en #(.READ_LATENCY(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
        .drive_n(drive_n), .store_n(store_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .sleep(sleep)
    );

    sram_dual_en #(.READ_LATENCY(1)) u_dut_reg (
        .clk(clk), .rst_n(rst_n), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
        .drive_n(drive_n), .store_n(store_n), .addr(addr), .wdata(wdata),
        .rdata(rdata_p), .rdata_oe(rdata_oe_p), .sleep(sleep_p)
    );

    function automatic logic [DW-1:0] pat(input int a, input int p);
        return DW'((a * 37 + (a >> 8) + p * 91 + 5) & 255);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, settle, then sampling may follow.
    task automatic drive(input logic lo_n, input logic hi, input logic dn, input logic sn,
                         input int a, input logic [DW-1:0] d);
        @(negedge clk);
        sel_lo_n = lo_n; sel_hi = hi; drive_n = dn; store_n = sn;
        addr = AW'(a); wdata = d;
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        // R10: reset state
        repeat (3) @(negedge clk);
        check(rdata_oe == 1'b0, "R10 oe in reset", rdata_oe, 0);
        check(rdata_oe_p == 1'b0, "R10 reg oe in reset", rdata_oe_p, 0);
        check(sleep == 1'b1, "R5 sleep in reset", sleep, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdata_oe_p == 1'b0, "R10 reg oe after reset", rdata_oe_p, 0);

        // R1 R2: fill every address, drive_n toggled to show it has no effect
        for (int a = 0; a < WORDS; a++) begin
            model[a] = pat(a, 0);
            drive(1'b0, 1'b1, a[0], 1'b0, a, model[a]);
            check(rdata_oe == 1'b0, "R4 no drive while storing", rdata_oe, 0);
            check(rdata == '0, "R8 zero while storing", rdata, 0);
        end

        // R1 R3 R9: read back every address, registered copy one cycle behind
        for (int a = 0; a < WORDS; a++) begin
            drive(1'b0, 1'b1, 1'b0, 1'b1, a, 8'h00);
            check(rdata_oe == 1'b1, "R3 oe on read", rdata_oe, 1);
            check(rdata == model[a], "R1 read data", rdata, model[a]);
            if (a == 0) begin
                check(rdata_oe_p == 1'b0, "R9 reg oe after store cycle", rdata_oe_p, 0);
            end else begin
                check(rdata_oe_p == 1'b1, "R9 reg oe", rdata_oe_p, 1);
                check(rdata_p == model[a-1], "R9 reg data", rdata_p, model[a-1]);
            end
        end

        // R5 R6 R7: blocked stores, flags and silent pin
        for (int i = 0; i < 64; i++) begin
            int a;
            a = i * 128 + (i % 4);
            drive(1'b1, i[0], i[1], 1'b0, a, ~model[a]);
            check(sleep == 1'b1, "R5 sleep flag", sleep, 1);
            check(rdata_oe == 1'b0, "R5 no drive in sleep", rdata_oe, 0);
            drive(1'b0, 1'b0, i[1], 1'b0, a, ~model[a]);
            check(sleep == 1'b0, "R6 no sleep when high select off", sleep, 0);
            check(rdata_oe == 1'b0, "R6 no drive unselected", rdata_oe, 0);
            drive(1'b0, 1'b0, 1'b0, 1'b1, a, ~model[a]);
            check(rdata_oe == 1'b0, "R6 no drive on read attempt", rdata_oe, 0);
            drive(1'b0, 1'b1, 1'b1, 1'b1, a, ~model[a]);
            check(rdata_oe == 1'b0, "R7 quiet no drive", rdata_oe, 0);
            check(rdata == '0, "R8 zero when quiet", rdata, 0);
            drive(1'b0, 1'b1, 1'b0, 1'b1, a, 8'h00);
            check(rdata == model[a], "R5 R6 R7 value unchanged", rdata, model[a]);
        end

        // R2 R3: store then read the same address in the very next cycle
        for (int a = 0; a < WORDS; a++) begin
            model[a] = pat(a, 1);
            drive(1'b0, 1'b1, ~a[1], 1'b0, a, model[a]);
            drive(1'b0, 1'b1, 1'b0, 1'b1, a, ~model[a]);
            check(rdata == model[a], "R3 read after store", rdata, model[a]);
        end

        // R1: neighbours were not disturbed by the second pass
        for (int a = 0; a < WORDS; a += 97) begin
            drive(1'b0, 1'b1, 1'b0, 1'b1, a, 8'h00);
            check(rdata == model[a], "R1 final contents", rdata, model[a]);
        end

        drive(1'b1, 1'b0, 1'b1, 1'b1, 0, 8'h00);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule